// File: doc/BRIEF.md
# Debug Halt Decision Unit

This block decides, at each instruction boundary of a simple in-order CPU core, whether the core must stop and hand control to an external debugger. It watches the instruction about to issue (its address, opcode, a valid strobe and a flag for instructions fed through the debugger's replacement path). It also watches an asynchronous event pin, an abort strobe, an ordinary halt request, a pending-exception flag and the core's status word. Control inputs come from a debugger-written control register: trap-on-zero-opcode enable, single-step enable and a 2-bit event-pin mode.

When it decides to halt, the block raises a one-cycle entry pulse and a level that shows debug mode is active. It reports the winning cause as a code and sets one sticky flag for every cause that applied. It also captures the address and status word of the instruction that was held back. A return command leaves debug mode. If single stepping is enabled, exactly one program instruction runs after the return and the core halts again at the next boundary.

All outputs are registered. The entry decision is taken in the cycle the boundary is presented and shows on the outputs after the next clock edge. The core must not retire the instruction presented in that cycle.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: An instruction with an all-zero opcode causes entry only when the trap-zero enable input is high. With the enable low it causes no entry and the block stays out of debug mode.
- R2: A trapped all-zero opcode sets cause flag bit 2 and reports entry code 3.
- R3: An all-zero opcode that arrives through the replacement path (repl flag high) while in debug mode causes no new entry pulse, and debug mode stays active.
- R4: When a return command is accepted with single-step enabled, the first program instruction after it executes without entry. The next instruction boundary then causes entry with cause flag bit 3 and entry code 4.
- R5: With event mode 2'b01, a falling edge on the event pin causes entry at the next instruction boundary after the two-flop synchronizer, setting cause flag bit 1 and code 2. With any other mode value an edge causes no entry.
- R6: A low pulse on the event pin lasting one clock cycle is enough to trigger the event entry.
- R7: An abort strobe outside debug mode forces entry on the next clock edge, even without a valid instruction, while the status word's mask bit (bit 21) is set and while an exception is pending.
- R8: Abort entry sets cause flag bit 0, the same flag as an ordinary halt request, and reports code 1.
- R9: On every entry the saved address and saved status equal the instruction address and status word presented in the deciding cycle, i.e. the instruction that was not executed.
- R10: An ordinary halt request is ignored while status bit 21 is set or an exception is pending. Once both are clear it is taken at the next instruction boundary with code 5 and cause flag bit 0.
- R11: When several causes apply in one cycle, the code follows the priority abort (1) > event (2) > zero trap (3) > step (4) > request (5), and every applicable cause flag is set.
- R12: Cause flags are sticky. A flag clears only when a one is written to its bit of the clear input, and a new set in the same cycle wins over the clear.
- R13: After reset the block is out of debug mode with all cause flags zero and no entry pulse. A return command taken in debug mode leaves it on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is at the boundary this cycle |
| instr_pc | input | AW | Address of the next not-yet-executed instruction |
| instr_opcode | input | OPW | Opcode of that instruction |
| instr_from_repl | input | 1 | Instruction comes from the debugger replacement path |
| cpu_sr | input | SRW | Current status word (bit DM_BIT masks halt requests) |
| exc_pending | input | 1 | An exception is pending in the core |
| halt_req | input | 1 | Ordinary debugger halt request (level) |
| abort_cmd | input | 1 | Abort strobe from the control register |
| trap_zero_en | input | 1 | Enable trapping of the all-zero opcode |
| step_en | input | 1 | Single-step enable |
| evt_mode | input | 2 | Event pin mode; 2'b01 enables falling-edge breakpoints |
| evt_pin | input | 1 | Asynchronous external event pin |
| ret_cmd | input | 1 | Return-from-debug command |
| cause_clr | input | 4 | Write-one-to-clear mask for the cause flags |
| dbg_enter | output | 1 | One-cycle pulse on debug entry |
| dbg_active | output | 1 | Core is in debug mode |
| entry_code | output | 3 | Winning cause of the most recent entry |
| cause_flags | output | 4 | Sticky causes: 0 request/abort, 1 event, 2 zero trap, 3 step |
| saved_pc | output | AW | Captured address of the held-back instruction |
| saved_sr | output | SRW | Captured status word |

## Verification
The bench targets an abort issued with the mask bit set, an exception pending and no valid instruction. A design that treated abort as an ordinary request would never halt there. It sends a zero opcode through the replacement path while halted, which a design missing the exemption would answer with a second entry pulse. It checks that single stepping lets exactly one instruction run: an off-by-one design halts at the wrong address. It also drives a one-cycle event pulse under both enabled and disabled modes, and stacks abort, event, zero trap and request in one cycle, where a wrong priority shows up as the wrong code or a missing flag.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int NCAUSE     = 4;
  localparam int CAUSE_REQ  = 0;
  localparam int CAUSE_EXT  = 1;
  localparam int CAUSE_ZERO = 2;
  localparam int CAUSE_STEP = 3;

  typedef enum logic [2:0] {
    EC_NONE  = 3'd0,
    EC_ABORT = 3'd1,
    EC_EVENT = 3'd2,
    EC_ZERO  = 3'd3,
    EC_STEP  = 3'd4,
    EC_REQ   = 3'd5
  } entry_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DUE   = 2'd2
  } step_state_e;
endpackage

// File: rtl/dbg_evt_det.sv
module dbg_evt_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       consume,
  input  logic       block,
  output logic       pend
);
  localparam logic [1:0] MODE_FALL = 2'b01;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   fall;

  // synchronizer chain, reset to the idle-high level
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= pin;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)                                 pend <= 1'b0;
    else if (mode != MODE_FALL || consume || block) pend <= 1'b0;
    else if (fall)                           pend <= 1'b1;
  end

  // R5: a pending event only arises under the falling-edge mode
  assert_evt_mode_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(mode) == MODE_FALL);
endmodule

// File: rtl/dbg_step_ctl.sv
module dbg_step_ctl
  import dbg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ret_take,
  input  logic step_en,
  input  logic instr_exec,
  input  logic enter,
  output logic due
);
  step_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (ret_take && step_en) state_d = ST_ARMED;
      ST_ARMED: if (enter) state_d = ST_IDLE;
                else if (instr_exec) state_d = ST_DUE;
      ST_DUE:   if (enter) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign due = (state_q == ST_DUE);

  // R4: the step halt becomes due only after one executed instruction
  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DUE && $past(state_q) == ST_ARMED) |-> $past(instr_exec));
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbg_pkg::*;
(
  input  logic              active,
  input  logic              abort,
  input  logic              valid,
  input  logic              evt_pend,
  input  logic              zero_hit,
  input  logic              step_due,
  input  logic              req_ok,
  output logic              enter,
  output entry_code_e       code,
  output logic [NCAUSE-1:0] hits
);
  logic b_evt, b_step, b_req;

  assign b_evt  = valid & evt_pend;
  assign b_step = valid & step_due;
  assign b_req  = valid & req_ok;

  always_comb begin
    enter = active & (abort | b_evt | zero_hit | b_step | b_req);
    code  = EC_NONE;
    if (active) begin
      if (abort)         code = EC_ABORT;
      else if (b_evt)    code = EC_EVENT;
      else if (zero_hit) code = EC_ZERO;
      else if (b_step)   code = EC_STEP;
      else if (b_req)    code = EC_REQ;
    end
    hits = '0;
    if (enter) begin
      hits[CAUSE_REQ]  = abort | b_req;
      hits[CAUSE_EXT]  = b_evt;
      hits[CAUSE_ZERO] = zero_hit;
      hits[CAUSE_STEP] = b_step;
    end
  end

  // R11: an entry always carries a cause code
  always_comb begin
    if (enter) assert_code_valid_R11: assert (code != EC_NONE);
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_pkg::*;
#(
  parameter int AW          = 32,
  parameter int OPW         = 16,
  parameter int SRW         = 32,
  parameter int DM_BIT      = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [AW-1:0]     instr_pc,
  input  logic [OPW-1:0]    instr_opcode,
  input  logic              instr_from_repl,
  input  logic [SRW-1:0]    cpu_sr,
  input  logic              exc_pending,
  input  logic              halt_req,
  input  logic              abort_cmd,
  input  logic              trap_zero_en,
  input  logic              step_en,
  input  logic [1:0]        evt_mode,
  input  logic              evt_pin,
  input  logic              ret_cmd,
  input  logic [NCAUSE-1:0] cause_clr,
  output logic              dbg_enter,
  output logic              dbg_active,
  output logic [2:0]        entry_code,
  output logic [NCAUSE-1:0] cause_flags,
  output logic [AW-1:0]     saved_pc,
  output logic [SRW-1:0]    saved_sr
);
  logic              active, ret_take, zero_hit, req_ok;
  logic              evt_pend, step_due, enter;
  logic              instr_exec;
  entry_code_e       code;
  logic [NCAUSE-1:0] hits;

  assign active     = ~dbg_active;
  assign ret_take   = ret_cmd & dbg_active;
  assign zero_hit   = active & instr_valid & ~instr_from_repl &
                      (instr_opcode == '0) & trap_zero_en;
  assign req_ok     = halt_req & ~cpu_sr[DM_BIT] & ~exc_pending;
  assign instr_exec = active & instr_valid & ~instr_from_repl & ~enter;

  dbg_evt_det #(.SYNC_STAGES(SYNC_STAGES)) evt_i (
    .clk(clk), .rst(rst), .pin(evt_pin), .mode(evt_mode),
    .consume(enter), .block(dbg_active), .pend(evt_pend)
  );

  dbg_step_ctl step_i (
    .clk(clk), .rst(rst), .ret_take(ret_take), .step_en(step_en),
    .instr_exec(instr_exec), .enter(enter), .due(step_due)
  );

  dbg_entry_arb arb_i (
    .active(active), .abort(abort_cmd), .valid(instr_valid),
    .evt_pend(evt_pend), .zero_hit(zero_hit), .step_due(step_due),
    .req_ok(req_ok), .enter(enter), .code(code), .hits(hits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_active  <= 1'b0;
      dbg_enter   <= 1'b0;
      entry_code  <= EC_NONE;
      cause_flags <= '0;
      saved_pc    <= '0;
      saved_sr    <= '0;
    end else begin
      dbg_enter   <= enter;
      cause_flags <= (cause_flags & ~cause_clr) | hits;
      if (enter) begin
        dbg_active <= 1'b1;
        entry_code <= code;
        saved_pc   <= instr_pc;
        saved_sr   <= cpu_sr;
      end else if (ret_take) begin
        dbg_active <= 1'b0;
      end
    end
  end

  // R1: a zero-trap entry needs the enable
  assert_zero_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (dbg_enter && entry_code == EC_ZERO) |-> $past(trap_zero_en));

  // R2: trapped zero opcode lands in debug mode with its flag
  assert_zero_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (!dbg_active && instr_valid && !instr_from_repl && instr_opcode == '0 && trap_zero_en)
    |=> (dbg_active && cause_flags[CAUSE_ZERO]));

  // R3: replacement instructions never re-enter
  assert_repl_exempt_R3: assert property (@(posedge clk) disable iff (rst)
    (dbg_active && instr_valid && instr_from_repl && !ret_cmd) |=> (dbg_active && !dbg_enter));

  // R7 and R8: abort forces entry with the request flag
  assert_abort_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (abort_cmd && !dbg_active) |=> (dbg_enter && cause_flags[CAUSE_REQ] && entry_code == EC_ABORT));

  // R9: captured address is the held-back instruction
  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (abort_cmd && !dbg_active) |=> (saved_pc == $past(instr_pc) && saved_sr == $past(cpu_sr)));

  // R10: ordinary request only when unmasked and no exception pending
  assert_req_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (dbg_enter && entry_code == EC_REQ) |-> (!$past(cpu_sr[DM_BIT]) && !$past(exc_pending)));

  // R12: flags fall only under a clear write
  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(cause_flags) & ~cause_flags) & ~$past(cause_clr)) == '0));

  // R13: return command leaves debug mode
  assert_ret_R13: assert property (@(posedge clk) disable iff (rst)
    (dbg_active && ret_cmd) |=> !dbg_active);
endmodule

// File: tb/dbg_entry_ctrl_tb_top.sv
module dbg_entry_ctrl_tb_top;
  localparam int AW = 32, OPW = 16, SRW = 32, DM = 21;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           instr_valid = 1'b0;
  logic [AW-1:0]  instr_pc = '0;
  logic [OPW-1:0] instr_opcode = 16'h1234;
  logic           instr_from_repl = 1'b0;
  logic [SRW-1:0] cpu_sr = 32'h0000_00C3;
  logic           exc_pending = 1'b0;
  logic           halt_req = 1'b0;
  logic           abort_cmd = 1'b0;
  logic           trap_zero_en = 1'b0;
  logic           step_en = 1'b0;
  logic [1:0]     evt_mode = 2'b00;
  logic           evt_pin = 1'b1;
  logic           ret_cmd = 1'b0;
  logic [3:0]     cause_clr = '0;
  logic           dbg_enter, dbg_active;
  logic [2:0]     entry_code;
  logic [3:0]     cause_flags;
  logic [AW-1:0]  saved_pc;
  logic [SRW-1:0] saved_sr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // expected entry: {code, flags, pc, sr}
  typedef struct packed {
    logic [2:0]     code;
    logic [3:0]     flags;
    logic [AW-1:0]  pc;
    logic [SRW-1:0] sr;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  dbg_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_pc(instr_pc),
    .instr_opcode(instr_opcode), .instr_from_repl(instr_from_repl),
    .cpu_sr(cpu_sr), .exc_pending(exc_pending), .halt_req(halt_req),
    .abort_cmd(abort_cmd), .trap_zero_en(trap_zero_en), .step_en(step_en),
    .evt_mode(evt_mode), .evt_pin(evt_pin), .ret_cmd(ret_cmd),
    .cause_clr(cause_clr), .dbg_enter(dbg_enter), .dbg_active(dbg_active),
    .entry_code(entry_code), .cause_flags(cause_flags),
    .saved_pc(saved_pc), .saved_sr(saved_sr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_entry(input logic [2:0] c, input logic [3:0] f, input logic [AW-1:0] pc);
    exp_t e;
    e.code = c; e.flags = f; e.pc = pc; e.sr = cpu_sr;
    sb_q.push_back(e);
  endtask

  // one boundary cycle; inputs change at negedge
  task automatic issue(input logic [AW-1:0] pc, input logic [OPW-1:0] op,
                       input logic repl, input logic abt);
    instr_valid = 1'b1; instr_pc = pc; instr_opcode = op;
    instr_from_repl = repl; abort_cmd = abt;
    @(negedge clk);
    instr_valid = 1'b0; instr_from_repl = 1'b0; abort_cmd = 1'b0;
    instr_opcode = 16'h1234;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic leave();
    ret_cmd = 1'b1; cause_clr = 4'hF;
    @(negedge clk);
    ret_cmd = 1'b0; cause_clr = 4'h0;
  endtask

  // monitor: scoreboard pops on each entry pulse
  always @(negedge clk) begin
    if (!rst && !done && dbg_enter === 1'b1) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R1/R3: unexpected entry actual code %0d expected no entry", entry_code);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R11 entry code", 64'(entry_code), 64'(e.code));
        check("R11/R12 cause flags", 64'(cause_flags), 64'(e.flags));
        check("R9 saved pc", 64'(saved_pc), 64'(e.pc));
        check("R9 saved sr", 64'(saved_sr), 64'(e.sr));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    check("R13 active after reset", 64'(dbg_active), 0);
    check("R13 flags after reset", 64'(cause_flags), 0);
    check("R13 no pulse after reset", 64'(dbg_enter), 0);

    // R1: zero opcode with trap disabled runs normally
    issue(32'h100, 16'h0000, 1'b0, 1'b0);
    idle(1);
    check("R1 no entry with trap off", 64'(dbg_active), 0);

    // R2: trap enabled
    trap_zero_en = 1'b1;
    expect_entry(3'd3, 4'b0100, 32'h104);
    issue(32'h104, 16'h0000, 1'b0, 1'b0);
    check("R2 active after trap", 64'(dbg_active), 1);

    // R3: replacement zero opcode inside debug mode
    issue(32'h104, 16'h0000, 1'b1, 1'b0);
    idle(1);
    check("R3 still active", 64'(dbg_active), 1);

    // R12: flags sticky, clear by one-write
    check("R12 flag held", 64'(cause_flags), 64'h4);
    cause_clr = 4'b1011; @(negedge clk); cause_clr = 4'b0;
    check("R12 untouched bit kept", 64'(cause_flags), 64'h4);
    cause_clr = 4'b0100; @(negedge clk); cause_clr = 4'b0;
    check("R12 cleared", 64'(cause_flags), 0);

    // R13: leave
    leave();
    check("R13 left debug", 64'(dbg_active), 0);
    trap_zero_en = 1'b0;

    // R10: request masked by status bit then by pending exception
    halt_req = 1'b1; cpu_sr[DM] = 1'b1;
    issue(32'h110, 16'h1111, 1'b0, 1'b0);
    issue(32'h112, 16'h1111, 1'b0, 1'b0);
    check("R10 masked by status bit", 64'(dbg_active), 0);
    cpu_sr[DM] = 1'b0; exc_pending = 1'b1;
    issue(32'h114, 16'h1111, 1'b0, 1'b0);
    check("R10 blocked by exception", 64'(dbg_active), 0);
    exc_pending = 1'b0;
    expect_entry(3'd5, 4'b0001, 32'h116);
    issue(32'h116, 16'h1111, 1'b0, 1'b0);
    check("R10 taken when clear", 64'(dbg_active), 1);
    halt_req = 1'b0;
    leave();

    // R7/R8: abort with mask set, exception pending, no valid instruction
    cpu_sr[DM] = 1'b1; exc_pending = 1'b1; instr_pc = 32'h200;
    expect_entry(3'd1, 4'b0001, 32'h200);
    abort_cmd = 1'b1; @(negedge clk); abort_cmd = 1'b0;
    check("R7 abort forced entry", 64'(dbg_active), 1);
    check("R8 abort request flag", 64'(cause_flags[0]), 1);
    cpu_sr[DM] = 1'b0; exc_pending = 1'b0;
    leave();

    // R5: edge ignored with mode 00
    evt_mode = 2'b00;
    evt_pin = 1'b0; idle(1); evt_pin = 1'b1;
    idle(4);
    issue(32'h300, 16'h1111, 1'b0, 1'b0);
    check("R5 mode 00 no entry", 64'(dbg_active), 0);

    // R6: one-cycle low pulse with mode 01
    evt_mode = 2'b01;
    evt_pin = 1'b0; idle(1); evt_pin = 1'b1;
    idle(4);
    expect_entry(3'd2, 4'b0010, 32'h304);
    issue(32'h304, 16'h1111, 1'b0, 1'b0);
    check("R6 one-cycle pulse entered", 64'(dbg_active), 1);

    // R4: single step after return
    step_en = 1'b1;
    leave();
    issue(32'h400, 16'h1111, 1'b0, 1'b0);
    check("R4 one instruction executed", 64'(dbg_active), 0);
    expect_entry(3'd4, 4'b1000, 32'h402);
    issue(32'h402, 16'h1111, 1'b0, 1'b0);
    check("R4 halted after step", 64'(dbg_active), 1);
    step_en = 1'b0;
    leave();

    // R11: abort, event, zero trap and request together
    trap_zero_en = 1'b1; halt_req = 1'b1;
    evt_pin = 1'b0; idle(1); evt_pin = 1'b1;
    idle(4);
    expect_entry(3'd1, 4'b0111, 32'h500);
    issue(32'h500, 16'h0000, 1'b0, 1'b1);
    leave();
    // event then zero trap without abort
    halt_req = 1'b0;
    evt_pin = 1'b0; idle(1); evt_pin = 1'b1;
    idle(4);
    expect_entry(3'd2, 4'b0110, 32'h504);
    issue(32'h504, 16'h0000, 1'b0, 1'b0);
    leave();
    trap_zero_en = 1'b0; evt_mode = 2'b00;

    idle(3);
    check("R11 scoreboard drained", 64'(sb_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule